// File: doc/BRIEF.md
# UART Modem Control and Loopback Unit

This unit holds the modem control byte of one UART channel and sits between the channel's pins and its core. A host writes the byte through a simple strobe port and reads it back. From the byte the unit drives the active-low handshake outputs, the interrupt output enable and the general purpose output. It also steers the serial data path and the four modem status lines that the core sees.

There are three routings. In the standard routing, transmit and receive data go straight between the core and the pins. In the infrared routing, data pass through an external pulse encoder and decoder, and the transmit pin rests low. In local loopback, the pins are cut off. The core's transmit data then returns to its receiver, and four bits of the control byte stand in for the modem status inputs, so a diagnostic can exercise every receive and status interrupt without any wiring.

Top module: `uart_modem_link`

## Requirements
- R1: After reset, rd_data is 0x00, rts_n and dtr_n are 1, irq_oe is 0, op2_out is 1, and the standard routing is active.
- R2: A byte written with wr_en is visible on rd_data and on the outputs after the next rising clock edge. Bits 7 and 5 always read 0 and change no output. With wr_en low the byte holds.
- R3: Outside loopback, rts_n is the inverse of bit 1 and dtr_n is the inverse of bit 0.
- R4: Bit 3 drives irq_oe directly and op2_out inversely, in every mode including loopback.
- R5: With bits 4 and 6 clear, tx_pin equals core_tx and core_rx equals pin_rx.
- R6: With bit 6 set and bit 4 clear, core_rx equals dec_rx. tx_pin equals enc_pulse while core_tx is 0 and is 0 while core_tx is 1, so an idle line rests low.
- R7: With bit 4 set, core_rx equals core_tx, and rts_n and dtr_n are 1. tx_pin rests at the idle level of the selected routing: 1 for standard and 0 for infrared.
- R8: With bit 4 set, the status outputs follow the byte: sts_cts = bit 1, sts_dsr = bit 0, sts_ri = bit 2, sts_cd = bit 3. The four status pins have no effect.
- R9: Outside loopback, each status output is the inverse of its active-low pin (pin_cts_n, pin_dsr_n, pin_cd_n, pin_ri_n).
- R10: Outside loopback, bit 2 has no effect on any output other than rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | DATA_W | Control byte to write |
| rd_data | output | DATA_W | Control byte read-back, reserved bits zero |
| core_tx | input | 1 | Serial output of the UART core |
| core_rx | output | 1 | Serial input delivered to the UART core |
| enc_pulse | input | 1 | Output of the infrared pulse encoder |
| dec_rx | input | 1 | Output of the infrared pulse decoder |
| pin_rx | input | 1 | Receive data pin |
| tx_pin | output | 1 | Transmit data pin |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_cd_n | input | 1 | Carrier-detect pin, active low |
| pin_ri_n | input | 1 | Ring-indicator pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| op2_out | output | 1 | General purpose output, inverse of the interrupt enable |
| irq_oe | output | 1 | Output enable for the interrupt pin driver |
| sts_cts | output | 1 | Clear-to-send as seen by the core |
| sts_dsr | output | 1 | Data-set-ready as seen by the core |
| sts_cd | output | 1 | Carrier-detect as seen by the core |
| sts_ri | output | 1 | Ring-indicator as seen by the core |

## Verification
The assertions check on every cycle that writes land one edge later with the reserved bits cleared. They also check the handshake and interrupt-enable polarity, the loopback of serial data and of the four status lines, and the standard data path. Only the bench scenarios can show the infrared pulse gating and its low idle level, the loopback idle level under each routing, and the fact that bit 2 and the status pins leave the outputs untouched where they should. The bench also walks every combination of loopback, infrared and interrupt enable from reset.

// File: rtl/uart_mctl_pkg.sv
package uart_mctl_pkg;

    // Bit positions of the control byte (software decodes these).
    localparam int B_DTR  = 0;
    localparam int B_RTS  = 1;
    localparam int B_OP1  = 2;
    localparam int B_IRQE = 3;
    localparam int B_LOOP = 4;
    localparam int B_IR   = 6;
    localparam int CTL_W  = 8;
    localparam logic [CTL_W-1:0] WR_MASK = 8'h5F;

    typedef struct packed {
        logic ir_en;
        logic loop_en;
        logic irq_en;
        logic op1;
        logic rts;
        logic dtr;
    } mctl_t;

    typedef struct packed {
        logic cts;
        logic dsr;
        logic cd;
        logic ri;
    } mstat_t;

    typedef enum logic [1:0] {
        PATH_STD  = 2'd0,
        PATH_IR   = 2'd1,
        PATH_LOOP = 2'd2
    } path_e;

    function automatic mctl_t byte_to_ctl(input logic [CTL_W-1:0] b);
        mctl_t c;
        c.ir_en   = b[B_IR];
        c.loop_en = b[B_LOOP];
        c.irq_en  = b[B_IRQE];
        c.op1     = b[B_OP1];
        c.rts     = b[B_RTS];
        c.dtr     = b[B_DTR];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_to_byte(input mctl_t c);
        logic [CTL_W-1:0] b;
        b          = '0;
        b[B_IR]    = c.ir_en;
        b[B_LOOP]  = c.loop_en;
        b[B_IRQE]  = c.irq_en;
        b[B_OP1]   = c.op1;
        b[B_RTS]   = c.rts;
        b[B_DTR]   = c.dtr;
        return b;
    endfunction

    function automatic path_e pick_path(input mctl_t c);
        if (c.loop_en)     return PATH_LOOP;
        else if (c.ir_en)  return PATH_IR;
        else               return PATH_STD;
    endfunction

endpackage

// File: rtl/mctl_reg.sv
module mctl_reg
    import uart_mctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output mctl_t             ctl,
    output logic [DATA_W-1:0] rd_data
);
    mctl_t ctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= byte_to_ctl(wr_data[CTL_W-1:0] & WR_MASK);
    end

    assign ctl     = ctl_q;
    assign rd_data = DATA_W'(ctl_to_byte(ctl_q));
endmodule

// File: rtl/mctl_serial_mux.sv
module mctl_serial_mux
    import uart_mctl_pkg::*;
(
    input  mctl_t ctl,
    input  logic  core_tx,
    input  logic  pin_rx,
    input  logic  enc_pulse,
    input  logic  dec_rx,
    output logic  tx_pin,
    output logic  core_rx
);
    path_e path;
    assign path = pick_path(ctl);

    always_comb begin
        unique case (path)
            PATH_LOOP: begin
                core_rx = core_tx;
                tx_pin  = ~ctl.ir_en;          // idle level of the chosen routing
            end
            PATH_IR: begin
                core_rx = dec_rx;
                tx_pin  = enc_pulse & ~core_tx; // no light on a mark
            end
            default: begin
                core_rx = pin_rx;
                tx_pin  = core_tx;
            end
        endcase
    end
endmodule

// File: rtl/mctl_modem_mux.sv
module mctl_modem_mux
    import uart_mctl_pkg::*;
(
    input  mctl_t  ctl,
    input  mstat_t pins_n,
    output mstat_t stat,
    output logic   rts_n,
    output logic   dtr_n,
    output logic   irq_oe,
    output logic   op2_out
);
    mstat_t loop_stat;

    assign loop_stat.cts = ctl.rts;
    assign loop_stat.dsr = ctl.dtr;
    assign loop_stat.cd  = ctl.irq_en;
    assign loop_stat.ri  = ctl.op1;

    always_comb begin
        if (ctl.loop_en) begin
            stat  = loop_stat;
            rts_n = 1'b1;
            dtr_n = 1'b1;
        end else begin
            stat  = ~pins_n;
            rts_n = ~ctl.rts;
            dtr_n = ~ctl.dtr;
        end
    end

    assign irq_oe  = ctl.irq_en;
    assign op2_out = ~ctl.irq_en;
endmodule

// File: rtl/uart_modem_link.sv
module uart_modem_link
    import uart_mctl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              core_tx,
    output logic              core_rx,
    input  logic              enc_pulse,
    input  logic              dec_rx,
    input  logic              pin_rx,
    output logic              tx_pin,
    input  logic              pin_cts_n,
    input  logic              pin_dsr_n,
    input  logic              pin_cd_n,
    input  logic              pin_ri_n,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              op2_out,
    output logic              irq_oe,
    output logic              sts_cts,
    output logic              sts_dsr,
    output logic              sts_cd,
    output logic              sts_ri
);
    mctl_t  ctl;
    mstat_t pins_n;
    mstat_t stat;

    assign pins_n.cts = pin_cts_n;
    assign pins_n.dsr = pin_dsr_n;
    assign pins_n.cd  = pin_cd_n;
    assign pins_n.ri  = pin_ri_n;

    mctl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl),
        .rd_data (rd_data)
    );

    mctl_serial_mux u_ser (
        .ctl       (ctl),
        .core_tx   (core_tx),
        .pin_rx    (pin_rx),
        .enc_pulse (enc_pulse),
        .dec_rx    (dec_rx),
        .tx_pin    (tx_pin),
        .core_rx   (core_rx)
    );

    mctl_modem_mux u_mdm (
        .ctl     (ctl),
        .pins_n  (pins_n),
        .stat    (stat),
        .rts_n   (rts_n),
        .dtr_n   (dtr_n),
        .irq_oe  (irq_oe),
        .op2_out (op2_out)
    );

    assign sts_cts = stat.cts;
    assign sts_dsr = stat.dsr;
    assign sts_cd  = stat.cd;
    assign sts_ri  = stat.ri;
endmodule

// File: rtl/uart_modem_link_chk.sv
module uart_modem_link_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              core_tx,
    input logic              core_rx,
    input logic              pin_rx,
    input logic              tx_pin,
    input logic              pin_cts_n,
    input logic              pin_dsr_n,
    input logic              pin_cd_n,
    input logic              pin_ri_n,
    input logic              rts_n,
    input logic              dtr_n,
    input logic              op2_out,
    input logic              irq_oe,
    input logic              sts_cts,
    input logic              sts_dsr,
    input logic              sts_cd,
    input logic              sts_ri
);
    logic lp, ir;
    assign lp = rd_data[4];
    assign ir = rd_data[6];

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[7:0] == ($past(wr_data[7:0]) & 8'h5F));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[7] == 1'b0 && rd_data[5] == 1'b0);

    a_r3_handshake: assert property (@(posedge clk) disable iff (rst)
        !lp |-> (rts_n == !rd_data[1] && dtr_n == !rd_data[0]));

    a_r4_irq_op2: assert property (@(posedge clk) disable iff (rst)
        irq_oe == rd_data[3] && op2_out == !rd_data[3]);

    a_r5_std_path: assert property (@(posedge clk) disable iff (rst)
        (!lp && !ir) |-> (tx_pin == core_tx && core_rx == pin_rx));

    a_r7_loop_data: assert property (@(posedge clk) disable iff (rst)
        lp |-> (core_rx == core_tx && rts_n && dtr_n));

    a_r8_loop_status: assert property (@(posedge clk) disable iff (rst)
        lp |-> (sts_cts == rd_data[1] && sts_dsr == rd_data[0] &&
                sts_ri == rd_data[2] && sts_cd == rd_data[3]));

    a_r9_pin_status: assert property (@(posedge clk) disable iff (rst)
        !lp |-> (sts_cts == !pin_cts_n && sts_dsr == !pin_dsr_n &&
                 sts_cd == !pin_cd_n && sts_ri == !pin_ri_n));
endmodule

bind uart_modem_link uart_modem_link_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_tx(core_tx), .core_rx(core_rx), .pin_rx(pin_rx), .tx_pin(tx_pin),
    .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n), .pin_cd_n(pin_cd_n),
    .pin_ri_n(pin_ri_n), .rts_n(rts_n), .dtr_n(dtr_n), .op2_out(op2_out),
    .irq_oe(irq_oe), .sts_cts(sts_cts), .sts_dsr(sts_dsr), .sts_cd(sts_cd),
    .sts_ri(sts_ri)
);

// File: tb/uart_modem_link_bench.sv
module uart_modem_link_bench;
    localparam int  DATA_W = 8;
    localparam time CYC    = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic core_tx = 1'b1, core_rx, enc_pulse = 1'b0, dec_rx = 1'b1, pin_rx = 1'b1, tx_pin;
    logic pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_cd_n = 1'b1, pin_ri_n = 1'b1;
    logic rts_n, dtr_n, op2_out, irq_oe, sts_cts, sts_dsr, sts_cd, sts_ri;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CYC/2) clk = ~clk;

    uart_modem_link #(.DATA_W(DATA_W)) u_uart_modem_link (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .core_tx(core_tx), .core_rx(core_rx), .enc_pulse(enc_pulse), .dec_rx(dec_rx),
        .pin_rx(pin_rx), .tx_pin(tx_pin), .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
        .pin_cd_n(pin_cd_n), .pin_ri_n(pin_ri_n), .rts_n(rts_n), .dtr_n(dtr_n),
        .op2_out(op2_out), .irq_oe(irq_oe), .sts_cts(sts_cts), .sts_dsr(sts_dsr),
        .sts_cd(sts_cd), .sts_ri(sts_ri)
    );

    // {control byte, expected {rts_n, dtr_n, irq_oe, op2_out}}
    localparam logic [11:0] VEC [16] = '{
        {8'h00, 4'b1101}, {8'h03, 4'b0001}, {8'h08, 4'b1110}, {8'h0B, 4'b0010},
        {8'h10, 4'b1101}, {8'h13, 4'b1101}, {8'h18, 4'b1110}, {8'h1F, 4'b1110},
        {8'h40, 4'b1101}, {8'h42, 4'b0101}, {8'h48, 4'b1110}, {8'h49, 4'b1010},
        {8'h50, 4'b1101}, {8'h5B, 4'b1110}, {8'h44, 4'b1101}, {8'h0C, 4'b1110}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        #1;
    endtask

    // Expected serial pair {tx_pin, core_rx} from R5, R6, R7
    function automatic logic [1:0] exp_ser(input logic [7:0] c);
        if (c[4])      return {~c[6], core_tx};
        else if (c[6]) return {enc_pulse & ~core_tx, dec_rx};
        else           return {core_tx, pin_rx};
    endfunction

    // Expected {cts, dsr, cd, ri} from R8, R9
    function automatic logic [3:0] exp_sts(input logic [7:0] c);
        if (c[4]) return {c[1], c[0], c[3], c[2]};
        else      return ~{pin_cts_n, pin_dsr_n, pin_cd_n, pin_ri_n};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pins", {rts_n, dtr_n, irq_oe, op2_out}, 4'b1101);
        chk("R1 std path", {tx_pin, core_rx}, {core_tx, pin_rx});

        // Table walk: every loop/ir/irq-enable combination
        for (int i = 0; i < 16; i++) begin
            logic [7:0] c;
            c = VEC[i][11:4];
            write_ctl(c);
            chk("R2 readback", rd_data, c);
            chk("R3/R4 pin levels", {rts_n, dtr_n, irq_oe, op2_out}, VEC[i][3:0]);
            for (int p = 0; p < 4; p++) begin
                core_tx   = p[0];
                pin_rx    = p[1];
                dec_rx    = p[0] ^ p[1];
                enc_pulse = 1'b1;
                {pin_cts_n, pin_dsr_n, pin_cd_n, pin_ri_n} = {p[1], p[0], ~p[0], ~p[1]};
                #1;
                chk(c[4] ? "R7 loop serial" : (c[6] ? "R6 ir serial" : "R5 std serial"),
                    {tx_pin, core_rx}, exp_ser(c));
                chk(c[4] ? "R8 loop status" : "R9 pin status",
                    {sts_cts, sts_dsr, sts_cd, sts_ri}, exp_sts(c));
            end
        end

        // R2 reserved bits dropped, no effect on outputs
        write_ctl(8'hA0);
        chk("R2 reserved readback", rd_data, 8'h00);
        chk("R2 reserved no effect", {rts_n, dtr_n, irq_oe, op2_out}, 4'b1101);
        core_tx = 1'b0; pin_rx = 1'b1; #1;
        chk("R2 reserved path", {tx_pin, core_rx}, 2'b01);
        write_ctl(8'hFF);
        chk("R2 mask all ones", rd_data, 8'h5F);

        // R2 write timing and hold
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h03;
        @(posedge clk); #1;
        chk("R2 not before edge", rd_data, 8'h03);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h48;
        repeat (2) @(negedge clk);
        #1;
        chk("R2 hold without strobe", rd_data, 8'h03);

        // R6 infrared idle rests low
        write_ctl(8'h40);
        core_tx = 1'b1; enc_pulse = 1'b1; #1;
        chk("R6 ir idle low", tx_pin, 1'b0);
        core_tx = 1'b0; enc_pulse = 1'b1; #1;
        chk("R6 ir pulse passes", tx_pin, 1'b1);

        // R10 bit 2 has no effect outside loopback
        write_ctl(8'h00);
        core_tx = 1'b1; pin_rx = 1'b0;
        {pin_cts_n, pin_dsr_n, pin_cd_n, pin_ri_n} = 4'b1010;
        #1;
        write_ctl(8'h04);
        chk("R10 op1 outputs", {rts_n, dtr_n, irq_oe, op2_out, tx_pin, core_rx}, 6'b110110);
        chk("R10 op1 status", {sts_cts, sts_dsr, sts_cd, sts_ri}, 4'b0101);

        // R8 pins ignored in loopback
        write_ctl(8'h16);
        {pin_cts_n, pin_dsr_n, pin_cd_n, pin_ri_n} = 4'b0000; #1;
        chk("R8 pins ignored", {sts_cts, sts_dsr, sts_cd, sts_ri}, 4'b1001);

        // R1 reset from a busy state
        write_ctl(8'h5B);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 reset again", rd_data, 0);
        chk("R1 reset pins", {rts_n, dtr_n, irq_oe, op2_out}, 4'b1101);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule